// File: doc/BRIEF.md
# Auxiliary Packet Replay Scheduler

This block keeps a few auxiliary data packets (infoframes) in a local dual-port RAM. Once per video frame it plays every active packet out as a byte stream toward a downstream packet inserter. Software loads the packet words through a simple word-wide register port. It then selects slots with per-slot enable bits and a global RAM switch. A per-slot status bit shows what the transmitter is really using. A slot that carries infoframe type code T lives in slot T minus 0x80.

The status bits follow the enable bits only when a start-of-frame pulse is accepted. A packet is therefore never swapped in the middle of transmission. To rewrite a slot, software clears its enable bit and waits until the status bit drops at a later frame boundary. Seven payload bytes are packed into each pair of 32-bit words. The scheduler unpacks them back into byte order as it reads the RAM.

Register map: address bit 6 set selects control space. Control offset 0 is the configuration word: bits [NUM_SLOTS-1:0] are the slot enables and bit 31 is the RAM enable. Control offset 1 is the status word: bits [NUM_SLOTS-1:0] are the slot status bits and bit 16 is the sticky write-conflict flag, which is cleared by writing 1 to bit 16. With address bit 6 clear, bits [5:0] address a packet RAM word. Register reads return data one cycle after `reg_rd`.

Top module: `ifr_pkt_sched`

## Requirements
- R1: Slot s occupies RAM words s*10 through s*10+9. A write with address bit 6 clear and word address below 40 stores `reg_wdata` at that word.
- R2: A packet is 31 bytes read from the slot's words 0 to 8. Even words supply bytes from lanes [7:0], [15:8], [23:16]. Odd words supply lanes [7:0] through [31:24]. `out_first` marks byte 0 and `out_last` marks byte 30.
- R3: Every byte of a packet from slot s carries `out_type` = 0x80 + s.
- R4: Status bits change only when a start-of-frame pulse is accepted. They then take the value of the enable bits if bit 31 is set. Enable changes between frames leave status unchanged.
- R5: If the RAM enable is 0 (for example after writing 0 to the configuration word), an accepted frame start clears all status bits and no bytes are sent.
- R6: After an accepted frame start, each slot whose status bit is set is sent exactly once, in ascending slot order.
- R7: While `out_valid` is high and `out_ready` is low, `out_data`, `out_type`, `out_first`, `out_last` and `out_valid` hold. No byte is lost or duplicated.
- R8: A frame start that arrives while a frame's packets are still being scheduled is ignored. Status stays unchanged and sending does not restart.
- R9: A RAM write into a slot whose status bit is set is stored and sets status bit 16. The bit stays set until 1 is written to bit 16 of the status word. A write into a slot with status clear does not set it.
- R10: After reset the configuration, status and conflict flag read as 0 and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register or RAM write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_addr | input | 7 | Word address (bit 6 selects control space) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| sof | input | 1 | Start-of-frame pulse |
| out_data | output | 8 | Packet byte |
| out_type | output | 8 | Packet type code of the current byte |
| out_first | output | 1 | First byte of a packet |
| out_last | output | 1 | Last byte of a packet |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
The assertions take three things for granted. Writes and reads never come in the same cycle. `sof` is a single-cycle pulse. Software does not rewrite a slot while the scheduler reads it, except for the one deliberate conflict write used to test the flag. The stimulus keeps to these rules by driving the register port one operation at a time from tasks. Start-of-frame pulses are one cycle long, and only one is sent on purpose while a frame is busy. Slots are reloaded only while every status bit is clear. The ready signal is randomised, so stalls land on every byte position, including packet boundaries.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LATCH,
    SQ_PICK,
    SQ_READ,
    SQ_EMIT
  } sq_state_t;

  localparam logic [7:0] TYPE_BASE = 8'h80;
endpackage

// File: rtl/ifr_packet_ram.sv
module ifr_packet_ram #(
  parameter int DEPTH = 40,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ifr_ctrl_regs.sv
module ifr_ctrl_regs #(
  parameter int NUM_SLOTS = 4,
  parameter int STRIDE    = 10,
  parameter int DEPTH     = 40,
  parameter int RAW       = 6,
  parameter int AW        = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 frame_go,
  output logic [NUM_SLOTS-1:0] status,
  output logic                 ram_we,
  output logic [RAW-1:0]       ram_waddr,
  output logic [31:0]          ram_wdata
);
  logic                 ctrl_sel, cfg_hit, sts_hit;
  logic [RAW-1:0]       off;
  logic [NUM_SLOTS-1:0] en_q;
  logic                 ram_en_q;
  logic                 err_q;
  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 err_set, err_clr;
  logic [31:0]          cfg_word, sts_word;

  assign ctrl_sel  = reg_addr[AW-1];
  assign off       = reg_addr[AW-2:0];
  assign cfg_hit   = ctrl_sel && (off == RAW'(0));
  assign sts_hit   = ctrl_sel && (off == RAW'(1));
  assign ram_we    = reg_wr && !ctrl_sel && (32'(off) < 32'(DEPTH));
  assign ram_waddr = off;
  assign ram_wdata = reg_wdata;

  // Map each RAM word address to the slot whose region holds it.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
    assign slot_hit[s] = (32'(off) >= 32'(s * STRIDE)) &&
                         (32'(off) <  32'((s + 1) * STRIDE));
  end

  assign err_set = ram_we && |(slot_hit & status);
  assign err_clr = reg_wr && sts_hit && reg_wdata[16];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      ram_en_q <= 1'b0;
      status   <= '0;
      err_q    <= 1'b0;
    end else begin
      if (reg_wr && cfg_hit) begin
        en_q     <= reg_wdata[NUM_SLOTS-1:0];
        ram_en_q <= reg_wdata[31];
      end
      if (frame_go) status <= ram_en_q ? en_q : '0;
      if (err_clr)      err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[NUM_SLOTS-1:0] = en_q;
    cfg_word[31] = ram_en_q;
    sts_word = '0;
    sts_word[NUM_SLOTS-1:0] = status;
    sts_word[16] = err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= cfg_hit ? cfg_word : (sts_hit ? sts_word : '0);
  end

  AST_STATUS_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    !frame_go |=> $stable(status)); // R4
  AST_RAM_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (frame_go && !ram_en_q) |=> (status == '0)); // R5
  AST_CONFLICT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q); // R9
endmodule

// File: rtl/ifr_sequencer.sv
module ifr_sequencer
  import ifr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int PKT_BYTES = 31,
  parameter int STRIDE    = 10,
  parameter int RAW       = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sof,
  input  logic [NUM_SLOTS-1:0] status,
  output logic                 frame_go,
  output logic                 ram_re,
  output logic [RAW-1:0]       ram_raddr,
  input  logic [31:0]          ram_rdata,
  output logic [7:0]           out_data,
  output logic [7:0]           out_type,
  output logic                 out_first,
  output logic                 out_last,
  output logic                 out_valid,
  input  logic                 out_ready
);
  localparam int SW        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int WW        = $clog2(STRIDE);
  localparam int LAST_R    = (PKT_BYTES - 1) % 7;
  localparam int LAST_WORD = 2 * ((PKT_BYTES - 1) / 7) + ((LAST_R >= 3) ? 1 : 0);
  localparam int LAST_LANE = (LAST_R >= 3) ? LAST_R - 3 : LAST_R;

  sq_state_t            state;
  logic [NUM_SLOTS-1:0] pending;
  logic [SW-1:0]        cur;
  logic [WW-1:0]        word;
  logic [1:0]           lane;
  logic                 at_last_word, word_end, can_load;

  function automatic logic [SW-1:0] lowest(input logic [NUM_SLOTS-1:0] m);
    lowest = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) if (m[i]) lowest = SW'(i);
  endfunction

  assign frame_go     = sof && (state == SQ_IDLE);
  assign ram_re       = (state == SQ_READ);
  assign ram_raddr    = RAW'(int'(cur) * STRIDE + int'(word));
  assign at_last_word = (32'(word) == 32'(LAST_WORD));
  assign word_end     = at_last_word ? (32'(lane) == 32'(LAST_LANE))
                                     : (word[0] ? (lane == 2'd3) : (lane == 2'd2));
  assign can_load     = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      pending   <= '0;
      cur       <= '0;
      word      <= '0;
      lane      <= '0;
      out_data  <= '0;
      out_type  <= '0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      unique case (state)
        SQ_IDLE:  if (frame_go) state <= SQ_LATCH;
        SQ_LATCH: begin
          pending <= status;
          state   <= SQ_PICK;
        end
        SQ_PICK: begin
          if (pending == '0) state <= SQ_IDLE;
          else begin
            cur   <= lowest(pending);
            word  <= '0;
            state <= SQ_READ;
          end
        end
        SQ_READ: begin
          lane  <= '0;
          state <= SQ_EMIT;
        end
        SQ_EMIT: begin
          if (can_load) begin
            out_data  <= ram_rdata[8*lane +: 8];
            out_type  <= TYPE_BASE + 8'(cur);
            out_first <= (word == '0) && (lane == 2'd0);
            out_last  <= at_last_word && word_end;
            out_valid <= 1'b1;
            if (word_end) begin
              if (at_last_word) begin
                pending[cur] <= 1'b0;
                state        <= SQ_PICK;
              end else begin
                word  <= word + 1'b1;
                state <= SQ_READ;
              end
            end else begin
              lane <= lane + 1'b1;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_type)
                                   && $stable(out_first) && $stable(out_last))); // R7
  AST_TYPE_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_type >= TYPE_BASE) && (out_type < TYPE_BASE + 8'(NUM_SLOTS)))); // R3
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (sof && state != SQ_IDLE) |=> (state != SQ_LATCH)); // R8
endmodule

// File: rtl/ifr_pkt_sched.sv
module ifr_pkt_sched #(
  parameter int NUM_SLOTS = 4,
  parameter int PKT_BYTES = 31,
  localparam int STRIDE = 2 * ((PKT_BYTES + 6) / 7),
  localparam int DEPTH  = NUM_SLOTS * STRIDE,
  localparam int RAW    = $clog2(DEPTH),
  localparam int AW     = RAW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          sof,
  output logic [7:0]    out_data,
  output logic [7:0]    out_type,
  output logic          out_first,
  output logic          out_last,
  output logic          out_valid,
  input  logic          out_ready
);
  logic [NUM_SLOTS-1:0] status;
  logic                 frame_go;
  logic                 ram_we, ram_re;
  logic [RAW-1:0]       ram_waddr, ram_raddr;
  logic [31:0]          ram_wdata, ram_rdata;

  ifr_ctrl_regs #(.NUM_SLOTS(NUM_SLOTS), .STRIDE(STRIDE), .DEPTH(DEPTH),
                  .RAW(RAW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_go(frame_go),
    .status(status), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  ifr_packet_ram #(.DEPTH(DEPTH), .AW(RAW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
  );

  ifr_sequencer #(.NUM_SLOTS(NUM_SLOTS), .PKT_BYTES(PKT_BYTES), .STRIDE(STRIDE),
                  .RAW(RAW)) u_seq (
    .clk(clk), .rst(rst), .sof(sof), .status(status), .frame_go(frame_go),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .out_data(out_data), .out_type(out_type), .out_first(out_first),
    .out_last(out_last), .out_valid(out_valid), .out_ready(out_ready)
  );
endmodule

// File: tb/sim_ifr_pkt_sched.sv
module sim_ifr_pkt_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, sof = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  out_data, out_type;
  logic        out_first, out_last, out_valid;
  logic        out_ready = 1'b1;

  ifr_pkt_sched u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sof(sof), .out_data(out_data),
    .out_type(out_type), .out_first(out_first), .out_last(out_last),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] bm [40];
  logic [7:0]  rx_b [512];
  logic [7:0]  rx_t [512];
  logic        rx_f [512];
  logic        rx_l [512];
  int          rx_cnt = 0;
  int          stall_viol = 0;
  logic        rdy_rand = 1'b0;
  logic        prev_stall = 1'b0;
  logic [7:0]  prev_data = '0;

  // Ready is changed first, then the transfer that the next edge performs is recorded.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall && (!out_valid || out_data != prev_data)) stall_viol++;
      out_ready = rdy_rand ? (($urandom % 3) != 0) : 1'b1;
      if (out_valid && out_ready && rx_cnt < 512) begin
        rx_b[rx_cnt] = out_data; rx_t[rx_cnt] = out_type;
        rx_f[rx_cnt] = out_first; rx_l[rx_cnt] = out_last;
        rx_cnt++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_up();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic fill_slot(input int s);
    for (int w = 0; w < 10; w++) begin
      bm[s*10+w] = $urandom;
      wr(7'(s*10+w), bm[s*10+w]);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int s, input int b);
    int g, r, w, ln;
    g = b / 7; r = b % 7;
    w = 2 * g + ((r >= 3) ? 1 : 0);
    ln = (r >= 3) ? r - 3 : r;
    return bm[s*10+w][8*ln +: 8];
  endfunction

  task automatic run_frame(input logic [3:0] mask, input bit mid_sof);
    int exp_n, k, bad, tmo;
    bit mid_done;
    rx_cnt = 0; mid_done = 0;
    exp_n = $countones(mask) * 31;
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    tmo = 0;
    while (rx_cnt < exp_n && tmo < 4000) begin
      @(posedge clk); tmo++;
      if (mid_sof && !mid_done && rx_cnt >= 10) begin
        mid_done = 1;
        @(negedge clk); sof = 1'b1;
        @(negedge clk); sof = 1'b0;
      end
    end
    repeat (60) @(posedge clk);
    chk(mid_sof ? "R8 byte count" : "R6 byte count", rx_cnt, exp_n);
    bad = 0; k = 0;
    for (int s = 0; s < 4; s++) begin
      if (mask[s]) begin
        for (int b = 0; b < 31; b++) begin
          if (k < rx_cnt && bad == 0) begin
            if (rx_b[k] !== exp_byte(s, b) || rx_t[k] !== 8'(8'h80 + s) ||
                rx_f[k] !== (b == 0) || rx_l[k] !== (b == 30)) begin
              bad = 1;
              $display("FAIL R1 R2 R3 R6 slot %0d byte %0d: actual=%0h/%0h/%0b%0b expected=%0h/%0h/%0b%0b",
                       s, b, rx_b[k], rx_t[k], rx_f[k], rx_l[k],
                       exp_byte(s, b), 8'(8'h80 + s), (b == 0), (b == 30));
            end
          end
          k++;
        end
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  initial begin
    logic [31:0] d;
    logic [3:0]  m;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", 32'(out_valid), 0);
    rd(7'h40, d); chk("R10 config", d, 0);
    rd(7'h41, d); chk("R10 status", d, 0);

    for (int s = 0; s < 4; s++) fill_slot(s);
    wr(7'h40, 32'h8000_0005);
    rd(7'h41, d); chk("R4 status before frame", d, 0);
    run_frame(4'b0101, 0);
    rd(7'h41, d); chk("R4 status after frame", d, 32'h5);

    // R9 conflict flag
    bm[23] = $urandom; wr(7'd23, bm[23]);
    rd(7'h41, d); chk("R9 conflict set", d, 32'h0001_0005);
    wr(7'h41, 32'h0001_0000);
    rd(7'h41, d); chk("R9 conflict cleared", d, 32'h5);
    bm[10] = $urandom; wr(7'd10, bm[10]);
    rd(7'h41, d); chk("R9 idle slot write", d, 32'h5);

    // R4 enables change without frame, R8 busy frame start ignored
    wr(7'h40, 32'h8000_000A);
    rd(7'h41, d); chk("R4 status held", d, 32'h5);
    rdy_rand = 1'b1;
    run_frame(4'b1010, 1);
    rd(7'h41, d); chk("R8 status after busy sof", d, 32'hA);

    // R5 RAM enable off
    wr(7'h40, 32'h0000_000F);
    run_frame(4'b0000, 0);
    rd(7'h41, d); chk("R5 status cleared", d, 0);
    wr(7'h40, 32'h0);
    rd(7'h40, d); chk("R5 config zero", d, 0);

    for (int s = 0; s < 4; s++) fill_slot(s);
    for (int it = 0; it < 8; it++) begin
      m = 4'($urandom);
      if (it == 0) m = 4'hF;
      wr(7'h40, 32'h8000_0000 | 32'(m));
      run_frame(m, 0);
      rd(7'h41, d); chk("R4 random status", d, 32'(m));
    end
    chk("R7 stall hold", stall_viol, 0);
    finish_up();
  end
endmodule